// File: doc/BRIEF.md
# Hardware Breakpoint Address Matcher

This block compares every memory or I/O access event from a simple processor model against four programmable breakpoint slots. Each slot holds a linear address, a two-bit access-type code, a two-bit length code and separate local and global enable bits. An access event carries an address, a size code and a kind: fetch, read, write or I/O.

For each event the block reports, one clock later, a hit flag per slot. It also reports a combined exception request and whether that request is a fault or a trap. A fault comes from an execute slot and is detected before the instruction runs. A trap comes from a data or I/O slot and is reported after the access. A task-switch pulse drops every local enable and keeps the global ones.

An external resume input suppresses execute matches for the event it accompanies. A separate I/O-debug input gates the I/O access type.

Top module: `bkpt_matcher`

## Requirements
- R1: A write strobe with a slot index of 0 to 3 loads that slot's address, type, length, local enable and global enable. The new values apply to events driven from the next cycle on.
- R2: Event kind is encoded as 0 = fetch, 1 = read, 2 = write, 3 = I/O. Slot type 00 matches fetches only, type 01 matches writes only, and type 11 matches reads and writes but never fetches.
- R3: Slot type 10 matches I/O events only while `io_dbg_en` is 1. While it is 0, type 10 matches nothing.
- R4: Slot length 00, 01 and 11 cover 1, 2 and 4 bytes. Length 10 covers 8 bytes when parameter `LEN8_EN` is 1, and never matches when it is 0.
- R5: The event size code gives the access width: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. The slot address is aligned down to its length. A slot matches when any byte of the access falls inside the covered range.
- R6: An execute-type slot matches only when its length code is 00.
- R7: The hit flags appear one cycle after `ev_valid`. A flag is set for every matching slot, whatever its enables, and all flags are 0 in cycles with no event.
- R8: `req_o` is 1 exactly when at least one hit slot has its local or global enable set.
- R9: `fault_o` is 1 when an enabled hit slot has execute type. `trap_o` is 1 when an enabled hit slot has a data or I/O type.
- R10: A task-switch pulse clears all four local enables and leaves the global enables unchanged. A slot written in the same cycle takes the written values. An event in the same cycle as the pulse is judged with the enables in force before it.
- R11: While `resume` is 1, execute-type slots do not match the event and their hit flags stay 0. Data and I/O slots are not affected.
- R12: After a synchronous reset, all slot fields and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Slot configuration write strobe |
| cfg_slot | input | 2 | Slot index written |
| cfg_addr | input | AW | Breakpoint linear address |
| cfg_type | input | 2 | Access-type code |
| cfg_len | input | 2 | Length code |
| cfg_loc | input | 1 | Local enable |
| cfg_glb | input | 1 | Global enable |
| task_switch | input | 1 | Task-switch pulse |
| io_dbg_en | input | 1 | Enables I/O type 10 |
| resume | input | 1 | Suppresses execute matches this event |
| ev_valid | input | 1 | Access event present |
| ev_addr | input | AW | Access address |
| ev_size | input | 2 | Access size code |
| ev_kind | input | 2 | Access kind code |
| hit_o | output | 4 | Per-slot hit flags |
| req_o | output | 1 | Exception request |
| fault_o | output | 1 | Request classed as fault |
| trap_o | output | 1 | Request classed as trap |
| valid_o | output | 1 | Outputs belong to an event |

## Verification
A task-switch pulse can coincide with a configuration write and with an access event. The bench drives all three in one cycle. It expects the event to be judged with the local enable still set. It expects the written slot to keep its new local enable while the other local enables clear. A follow-up event at each slot address then shows at the request output which enables survived.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  typedef enum logic [1:0] {
    K_FETCH = 2'b00,
    K_READ  = 2'b01,
    K_WRITE = 2'b10,
    K_IO    = 2'b11
  } ev_kind_e;

  typedef enum logic [1:0] {
    T_EXEC = 2'b00,
    T_WR   = 2'b01,
    T_IO   = 2'b10,
    T_RW   = 2'b11
  } bp_type_e;

  // Byte-offset mask of a slot length code; bit 3 flags a usable code.
  function automatic logic [3:0] len_mask(input logic [1:0] len, input logic len8);
    case (len)
      2'b00:   len_mask = 4'b1000;
      2'b01:   len_mask = 4'b1001;
      2'b11:   len_mask = 4'b1011;
      default: len_mask = len8 ? 4'b1111 : 4'b0000;
    endcase
  endfunction

  // Byte-offset mask of an event size code.
  function automatic logic [2:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   size_mask = 3'd0;
      2'b01:   size_mask = 3'd1;
      2'b10:   size_mask = 3'd3;
      default: size_mask = 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/bkpt_slot_regs.sv
module bkpt_slot_regs #(
  parameter int AW    = 32,
  parameter int NSLOT = 4,
  localparam int SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [SW-1:0]             cfg_slot,
  input  logic [AW-1:0]             cfg_addr,
  input  logic [1:0]                cfg_type,
  input  logic [1:0]                cfg_len,
  input  logic                      cfg_loc,
  input  logic                      cfg_glb,
  input  logic                      task_switch,
  output logic [NSLOT-1:0][AW-1:0]  addr_q,
  output logic [NSLOT-1:0][1:0]     type_q,
  output logic [NSLOT-1:0][1:0]     len_q,
  output logic [NSLOT-1:0]          loc_q,
  output logic [NSLOT-1:0]          glb_q
);
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic sel;
    assign sel = cfg_we && (cfg_slot == SW'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[i] <= '0;
        type_q[i] <= '0;
        len_q[i]  <= '0;
        loc_q[i]  <= 1'b0;
        glb_q[i]  <= 1'b0;
      end else if (sel) begin
        addr_q[i] <= cfg_addr;
        type_q[i] <= cfg_type;
        len_q[i]  <= cfg_len;
        loc_q[i]  <= cfg_loc;
        glb_q[i]  <= cfg_glb;
      end else if (task_switch) begin
        loc_q[i]  <= 1'b0;
      end
    end
  end

  // R10: a pulse without a write leaves no local enable and keeps globals.
  a_r10_local_clear: assert property (@(posedge clk) disable iff (rst)
    (task_switch && !cfg_we) |=> (loc_q == '0));
  a_r10_global_keep: assert property (@(posedge clk) disable iff (rst)
    (task_switch && !cfg_we) |=> $stable(glb_q));
endmodule

// File: rtl/bkpt_slot_cmp.sv
module bkpt_slot_cmp
  import bkpt_pkg::*;
#(
  parameter int AW      = 32,
  parameter bit LEN8_EN = 1'b1,
  localparam int W      = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] slot_addr,
  input  logic [1:0]    slot_type,
  input  logic [1:0]    slot_len,
  input  logic          io_dbg_en,
  input  logic          resume,
  input  logic [AW-1:0] ev_addr,
  input  logic [1:0]    ev_size,
  input  logic [1:0]    ev_kind,
  output logic          match_o,
  output logic          exec_o
);
  logic [3:0]   lm;
  logic [W-1:0] mask, base, lim, lo, hi;
  logic         kind_ok, overlap;

  assign lm      = len_mask(slot_len, LEN8_EN);
  assign mask    = W'(lm[2:0]);
  assign base    = {1'b0, slot_addr} & ~mask;
  assign lim     = base | mask;
  assign lo      = {1'b0, ev_addr};
  assign hi      = lo + W'(size_mask(ev_size));
  assign overlap = lm[3] && (lo <= lim) && (base <= hi);

  always_comb begin
    case (slot_type)
      T_EXEC:  kind_ok = (ev_kind == K_FETCH) && (slot_len == 2'b00) && !resume;
      T_WR:    kind_ok = (ev_kind == K_WRITE);
      T_IO:    kind_ok = (ev_kind == K_IO) && io_dbg_en;
      default: kind_ok = (ev_kind == K_READ) || (ev_kind == K_WRITE);
    endcase
  end

  assign match_o = kind_ok && overlap;
  assign exec_o  = (slot_type == T_EXEC);

  a_r6_exec_len_one: assert property (@(posedge clk) disable iff (rst)
    (match_o && exec_o) |-> (slot_len == 2'b00));
  a_r3_io_gated: assert property (@(posedge clk) disable iff (rst)
    (match_o && slot_type == T_IO) |-> io_dbg_en);
  a_r11_resume_masks: assert property (@(posedge clk) disable iff (rst)
    (match_o && exec_o) |-> !resume);
endmodule

// File: rtl/bkpt_combine.sv
module bkpt_combine #(
  parameter int NSLOT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  logic [NSLOT-1:0] match,
  input  logic [NSLOT-1:0] exec,
  input  logic [NSLOT-1:0] loc_en,
  input  logic [NSLOT-1:0] glb_en,
  output logic [NSLOT-1:0] hit_o,
  output logic             req_o,
  output logic             fault_o,
  output logic             trap_o,
  output logic             valid_o
);
  logic [NSLOT-1:0] armed;
  logic             f_n, t_n;

  assign armed = match & (loc_en | glb_en);
  assign f_n   = |(armed & exec);
  assign t_n   = |(armed & ~exec);

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o   <= '0;
      req_o   <= 1'b0;
      fault_o <= 1'b0;
      trap_o  <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= ev_valid;
      hit_o   <= ev_valid ? match : '0;
      req_o   <= ev_valid && (f_n || t_n);
      fault_o <= ev_valid && f_n;
      trap_o  <= ev_valid && t_n;
    end
  end

  a_r8_req_has_hit: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (hit_o != '0));
  a_r9_req_classed: assert property (@(posedge clk) disable iff (rst)
    req_o |-> (fault_o || trap_o));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> (hit_o == '0 && !req_o));
endmodule

// File: rtl/bkpt_matcher.sv
module bkpt_matcher #(
  parameter int AW      = 32,
  parameter bit LEN8_EN = 1'b1,
  localparam int NSLOT  = 4,
  localparam int SW     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [SW-1:0]    cfg_slot,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [1:0]       cfg_type,
  input  logic [1:0]       cfg_len,
  input  logic             cfg_loc,
  input  logic             cfg_glb,
  input  logic             task_switch,
  input  logic             io_dbg_en,
  input  logic             resume,
  input  logic             ev_valid,
  input  logic [AW-1:0]    ev_addr,
  input  logic [1:0]       ev_size,
  input  logic [1:0]       ev_kind,
  output logic [NSLOT-1:0] hit_o,
  output logic             req_o,
  output logic             fault_o,
  output logic             trap_o,
  output logic             valid_o
);
  logic [NSLOT-1:0][AW-1:0] s_addr;
  logic [NSLOT-1:0][1:0]    s_type, s_len;
  logic [NSLOT-1:0]         s_loc, s_glb, s_match, s_exec;

  bkpt_slot_regs #(.AW(AW), .NSLOT(NSLOT)) i_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
    .cfg_addr(cfg_addr), .cfg_type(cfg_type), .cfg_len(cfg_len),
    .cfg_loc(cfg_loc), .cfg_glb(cfg_glb), .task_switch(task_switch),
    .addr_q(s_addr), .type_q(s_type), .len_q(s_len),
    .loc_q(s_loc), .glb_q(s_glb)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
    bkpt_slot_cmp #(.AW(AW), .LEN8_EN(LEN8_EN)) i_cmp (
      .clk(clk), .rst(rst),
      .slot_addr(s_addr[i]), .slot_type(s_type[i]), .slot_len(s_len[i]),
      .io_dbg_en(io_dbg_en), .resume(resume),
      .ev_addr(ev_addr), .ev_size(ev_size), .ev_kind(ev_kind),
      .match_o(s_match[i]), .exec_o(s_exec[i])
    );
  end

  bkpt_combine #(.NSLOT(NSLOT)) i_comb (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .match(s_match),
    .exec(s_exec), .loc_en(s_loc), .glb_en(s_glb),
    .hit_o(hit_o), .req_o(req_o), .fault_o(fault_o), .trap_o(trap_o),
    .valid_o(valid_o)
  );
endmodule

// File: tb/test_bkpt_matcher.sv
`timescale 1ns/1ps
module test_bkpt_matcher;
  localparam int AW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 0, cfg_loc = 0, cfg_glb = 0, task_switch = 0;
  logic io_dbg_en = 0, resume = 0, ev_valid = 0;
  logic [1:0] cfg_slot = 0, cfg_type = 0, cfg_len = 0, ev_size = 0, ev_kind = 0;
  logic [AW-1:0] cfg_addr = 0, ev_addr = 0;
  logic [3:0] hit_o, hit_b;
  logic req_o, fault_o, trap_o, valid_o, req_b, fault_b, trap_b, valid_b;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_addr[4], m_typ[4], m_len[4];
  bit m_loc[4], m_glb[4];

  always #2 clk = ~clk;

  bkpt_matcher #(.AW(AW), .LEN8_EN(1'b1)) i_bkpt_matcher (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_addr(cfg_addr),
    .cfg_type(cfg_type), .cfg_len(cfg_len), .cfg_loc(cfg_loc), .cfg_glb(cfg_glb),
    .task_switch(task_switch), .io_dbg_en(io_dbg_en), .resume(resume),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_size(ev_size), .ev_kind(ev_kind),
    .hit_o(hit_o), .req_o(req_o), .fault_o(fault_o), .trap_o(trap_o), .valid_o(valid_o));

  bkpt_matcher #(.AW(AW), .LEN8_EN(1'b0)) i_bkpt_matcher_n8 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_addr(cfg_addr),
    .cfg_type(cfg_type), .cfg_len(cfg_len), .cfg_loc(cfg_loc), .cfg_glb(cfg_glb),
    .task_switch(task_switch), .io_dbg_en(io_dbg_en), .resume(resume),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_size(ev_size), .ev_kind(ev_kind),
    .hit_o(hit_b), .req_o(req_b), .fault_o(fault_b), .trap_o(trap_b), .valid_o(valid_b));

  function automatic bit slot_hit(int s, int kind, int ea, int sz, bit io, bit rs, bit len8);
    int lb, base, esz;
    bit ok;
    case (m_len[s])
      0: lb = 1;
      1: lb = 2;
      3: lb = 4;
      default: lb = len8 ? 8 : 0;
    endcase
    if (lb == 0) return 0;
    case (m_typ[s])
      0: ok = (kind == 0) && (m_len[s] == 0) && !rs;
      1: ok = (kind == 2);
      2: ok = (kind == 3) && io;
      default: ok = (kind == 1) || (kind == 2);
    endcase
    base = m_addr[s] - (m_addr[s] % lb);
    esz = 1 << sz;
    return ok && (ea <= base + lb - 1) && (base <= ea + esz - 1);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cfg_write(int s, int a, int t, int l, bit lo, bit gl);
    @(negedge clk);
    cfg_we = 1; cfg_slot = 2'(s); cfg_addr = AW'(a); cfg_type = 2'(t);
    cfg_len = 2'(l); cfg_loc = lo; cfg_glb = gl;
    m_addr[s] = a; m_typ[s] = t; m_len[s] = l; m_loc[s] = lo; m_glb[s] = gl;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Drive one event at a falling edge; judge the registered outputs one cycle later.
  task automatic ev_check(string tag, int kind, int ea, int sz, bit io, bit rs);
    logic [3:0] eh, eb;
    bit f, t;
    f = 0; t = 0;
    for (int s = 0; s < 4; s++) begin
      eh[s] = slot_hit(s, kind, ea, sz, io, rs, 1'b1);
      eb[s] = slot_hit(s, kind, ea, sz, io, rs, 1'b0);
      if (eh[s] && (m_loc[s] || m_glb[s])) begin
        if (m_typ[s] == 0) f = 1; else t = 1;
      end
    end
    ev_valid = 1; ev_kind = 2'(kind); ev_addr = AW'(ea); ev_size = 2'(sz);
    io_dbg_en = io; resume = rs;
    @(negedge clk);
    check(tag, "hit", hit_o, eh);
    check(tag, "req", req_o, f || t);
    check(tag, "fault", fault_o, f);
    check(tag, "trap", trap_o, t);
    check(tag, "hit_len8off", hit_b, eb);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      m_addr[s] = 0; m_typ[s] = 0; m_len[s] = 0; m_loc[s] = 0; m_glb[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12: idle outputs after reset
    check("R12", "valid", valid_o, 0);
    check("R12", "hit", hit_o, 0);
    // R7 R12: all slots reset to execute at 0, disabled: flags set, no request
    ev_check("R7", 0, 0, 0, 0, 0);
    check("R7", "hit_all", hit_o, 4'hF);
    check("R12", "req_idle", req_o, 0);
    ev_valid = 0;
    @(negedge clk);
    check("R7", "no_event", hit_o, 0);

    // R1 R9: data write slot with global enable gives a trap
    cfg_write(2, 'h80, 1, 3, 0, 1);
    ev_check("R1", 2, 'h82, 0, 0, 0);
    check("R9", "trap", trap_o, 1);

    // R10: task switch clears local, keeps global
    cfg_write(1, 'h20, 0, 0, 1, 0);
    cfg_write(3, 'h90, 3, 0, 1, 0);
    ev_check("R8", 0, 'h20, 0, 0, 0);
    check("R9", "fault", fault_o, 1);
    // Collision: pulse, write of slot 3 with local set, and an event on slot 1
    ev_valid = 1; ev_kind = 0; ev_addr = 'h20; ev_size = 0; resume = 0;
    task_switch = 1; cfg_we = 1; cfg_slot = 3; cfg_addr = 'h90; cfg_type = 3;
    cfg_len = 0; cfg_loc = 1; cfg_glb = 0;
    @(negedge clk);
    task_switch = 0; cfg_we = 0;
    check("R10", "req_pre_switch", req_o, 1);
    m_loc[0] = 0; m_loc[1] = 0; m_loc[2] = 0;
    ev_check("R10", 0, 'h20, 0, 0, 0);
    check("R10", "local_cleared", req_o, 0);
    ev_check("R10", 2, 'h82, 0, 0, 0);
    check("R10", "global_kept", req_o, 1);
    ev_check("R10", 1, 'h90, 0, 0, 0);
    check("R10", "written_local", req_o, 1);

    // R11: resume suppresses execute flag
    cfg_write(1, 'h20, 0, 0, 0, 1);
    ev_check("R11", 0, 'h20, 0, 0, 1);
    check("R11", "exec_masked", hit_o[1], 0);

    // R2 R3 R4 R5 R6 R8 R9 R11: sweep of slot 0 against a window of events
    cfg_write(1, 'h10, 1, 3, 0, 0);
    cfg_write(2, 'h10, 1, 3, 0, 0);
    cfg_write(3, 'h10, 1, 3, 0, 0);
    for (int t = 0; t < 4; t++)
      for (int l = 0; l < 4; l++)
        for (int k = 0; k < 8; k++) begin
          cfg_write(0, 'h40 + 3 * k, t, l, 0, 1);
          for (int kind = 0; kind < 4; kind++)
            for (int sz = 0; sz < 4; sz++)
              for (int ea = 'h38; ea < 'h58; ea++)
                ev_check("R5", kind, ea, sz, ea[0], ea[1] & ea[2]);
        end
    ev_valid = 0;
    @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule